// File: doc/BRIEF.md
# Keyed Independent Watchdog Timer

This block is a watchdog that counts down on the edges of a slow free-running clock. The slow clock reaches it as a plain input, and a two-stage synchronizer in the bus clock domain samples it. Each synchronized rising edge is one tick. A programmable divider groups the ticks into count steps. A 12-bit counter takes one count per step. When a step finds the counter already at zero, the block raises a reset request for one bus-clock cycle and reloads the counter.

Software reaches the block through a small word-wide register bus that has four registers. Every control action passes through magic values written to the key register. One value opens write access to the divider and reload registers, one refreshes the counter, and one starts the watchdog. A start cannot be undone. A strap input, sampled during reset, can make the watchdog run from reset with no software start. Accepted divider and reload writes take effect at the next slow tick. Until that tick, the status register shows them as pending.

Top module: `wdg_keyed_top`

## Requirements
- R1: After reset the key register (byte offset 0x0) reads 0, the divider register (offset 0x4) reads 0, the reload register (offset 0x8) reads 0xFFF, the status register (offset 0xC) reads 0, and `rst_req` is low.
- R2: A write of the full 32-bit word 0x0000_5555 to the key register opens write access. While access is open, writes land in divider bits 2:0 and reload bits 11:0 and read back at once. A key word with nonzero upper bits does not open access.
- R3: Divider and reload writes are ignored while access is closed. Any key write other than 0x0000_5555 closes access again.
- R4: Status bit 0 (divider) and bit 1 (reload) go to 1 when a write to that register is accepted. They return to 0 on the first slow tick after the write, and the new value takes effect in the count logic on that same tick.
- R5: A key write of 0x0000_CCCC starts the watchdog. Once it runs, no key value stops it; only reset does.
- R6: While it runs, a step that finds the counter at zero raises `rst_req` for exactly one cycle and reloads the counter. From a refresh or reload with value R and divider D, a timeout therefore follows (R+1)*D ticks, and the timeouts repeat with that same period.
- R7: Divider code c selects D = 4 << c for c = 0..6. Code 7 selects D = 256.
- R8: A key write of 0x0000_AAAA loads the counter from the active reload value and restarts the divider phase.
- R9: If `strap_n` is 0 during reset, the watchdog runs from reset without a start write. If it is 1, the counter stays idle until a start write.
- R10: Only rising edges of `slow_clk` count, after synchronization. A high level held for many bus cycles is one tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_n | input | 1 | Run-from-reset strap, active low, sampled during reset |
| slow_clk | input | 1 | Asynchronous slow clock that drives the count |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read access |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
The hardest case to reach is an exact timeout boundary after a refresh. Ticks arrive only through the synchronizer, so the bench has to know the precise tick on which a timeout falls. The bench makes each slow edge itself with a task of fixed bus-clock length. It sets up small divider and reload values, then counts request pulses one tick before and at the expected tick. The run-from-reset case is reached by resetting with the strap low and never writing the start key.

// File: rtl/wdg_pkg.sv
// Package: shared register indices and key values for the keyed watchdog.
// Assumes byte addressing with word-aligned registers.
package wdg_pkg;

    typedef enum logic [1:0] {
        REG_KEY  = 2'd0,
        REG_DIV  = 2'd1,
        REG_RLD  = 2'd2,
        REG_STAT = 2'd3
    } wdg_reg_e;

    localparam logic [31:0] KEY_OPEN    = 32'h0000_5555;
    localparam logic [31:0] KEY_REFRESH = 32'h0000_AAAA;
    localparam logic [31:0] KEY_START   = 32'h0000_CCCC;

endpackage

// File: rtl/wdg_edge_sync.sv
// Module: brings the asynchronous slow clock into the bus clock domain and
// turns each rising edge into a one-cycle tick.
// Assumes the slow clock is much slower than clk (at least 3 clk per phase).
module wdg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic tick
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Synchronizer shift chain plus one stage of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Tick on a synchronized low-to-high transition.
    assign tick = sync_q[STAGES-1] & ~prev_q;

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R10

endmodule

// File: rtl/wdg_keybus.sv
// Module: register bus front end. It decodes key words, keeps the write-open
// flag, holds the shadow divider and reload values, and tracks pending updates.
// Assumes single-cycle accesses; reads are combinational.
module wdg_keybus
    import wdg_pkg::*;
#(
    parameter int              DATA_W  = 32,
    parameter int              ADDR_W  = 4,
    parameter int              DIV_W   = 3,
    parameter int              RLD_W   = 12,
    parameter logic [RLD_W-1:0] RLD_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              apply,
    output logic [DIV_W-1:0]  div_shadow,
    output logic [RLD_W-1:0]  rld_shadow,
    output logic              refresh_cmd,
    output logic              start_cmd
);

    logic     open_q;
    logic     div_pend_q;
    logic     rld_pend_q;
    logic     aligned;
    wdg_reg_e reg_idx;
    logic     key_wr;
    logic     div_wr_ok;
    logic     rld_wr_ok;

    assign aligned   = (bus_addr[1:0] == 2'b00);
    assign reg_idx   = wdg_reg_e'(bus_addr[3:2]);
    assign key_wr    = bus_sel & bus_wr & aligned & (reg_idx == REG_KEY);
    assign div_wr_ok = bus_sel & bus_wr & aligned & (reg_idx == REG_DIV) & open_q;
    assign rld_wr_ok = bus_sel & bus_wr & aligned & (reg_idx == REG_RLD) & open_q;

    assign refresh_cmd = key_wr & (bus_wdata == DATA_W'(KEY_REFRESH));
    assign start_cmd   = key_wr & (bus_wdata == DATA_W'(KEY_START));

    // Write-open flag: every key write either opens or closes access.
    always_ff @(posedge clk) begin
        if (!rst_n)      open_q <= 1'b0;
        else if (key_wr) open_q <= (bus_wdata == DATA_W'(KEY_OPEN));
    end

    // Shadow divider code and its pending flag; the slow tick clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_shadow <= '0;
            div_pend_q <= 1'b0;
        end else if (div_wr_ok) begin
            div_shadow <= bus_wdata[DIV_W-1:0];
            div_pend_q <= 1'b1;
        end else if (apply) begin
            div_pend_q <= 1'b0;
        end
    end

    // Shadow reload value and its pending flag; the slow tick clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_shadow <= RLD_RST;
            rld_pend_q <= 1'b0;
        end else if (rld_wr_ok) begin
            rld_shadow <= bus_wdata[RLD_W-1:0];
            rld_pend_q <= 1'b1;
        end else if (apply) begin
            rld_pend_q <= 1'b0;
        end
    end

    // Read mux; the key register reads as zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && aligned) begin
            unique case (reg_idx)
                REG_KEY:  bus_rdata = '0;
                REG_DIV:  bus_rdata = DATA_W'(div_shadow);
                REG_RLD:  bus_rdata = DATA_W'(rld_shadow);
                REG_STAT: bus_rdata = DATA_W'({rld_pend_q, div_pend_q});
                default:  bus_rdata = '0;
            endcase
        end
    end

    AST_LOCKED_RLD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && aligned && reg_idx == REG_RLD && !open_q) |=> $stable(rld_shadow)); // R3

    AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && !rld_wr_ok) |=> !rld_pend_q); // R4

endmodule

// File: rtl/wdg_count_core.sv
// Module: slow-tick side of the watchdog. It holds the active divider and reload
// values, the divider phase, the down-counter, the run flag and the request.
// Assumes tick is a single-cycle pulse that never repeats on adjacent cycles.
module wdg_count_core #(
    parameter int               DIV_W    = 3,
    parameter int               RLD_W    = 12,
    parameter int               MAX_CODE = 6,
    parameter logic [RLD_W-1:0] RLD_RST  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_n,
    input  logic             tick,
    input  logic             start_cmd,
    input  logic             refresh_cmd,
    input  logic [DIV_W-1:0] div_shadow,
    input  logic [RLD_W-1:0] rld_shadow,
    output logic             rst_req
);

    localparam int PH_W = 2 + MAX_CODE;

    logic             running_q;
    logic [DIV_W-1:0] div_act_q;
    logic [RLD_W-1:0] rld_act_q;
    logic [PH_W-1:0]  phase_q;
    logic [RLD_W-1:0] cnt_q;
    logic             req_q;
    logic [DIV_W-1:0] shift;
    logic [PH_W:0]    div_last;
    logic             phase_end;
    logic             step;

    // Divider terminal value: (4 << code) - 1, with codes above MAX_CODE clamped.
    always_comb begin
        shift     = (div_act_q > DIV_W'(MAX_CODE)) ? DIV_W'(MAX_CODE) : div_act_q;
        div_last  = ((PH_W+1)'(4) << shift) - (PH_W+1)'(1);
        phase_end = ({1'b0, phase_q} >= div_last);
    end

    assign step    = running_q & tick & phase_end;
    assign rst_req = req_q;

    // Run flag: the strap sets it in reset, a start key sets it later; it is never cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)         running_q <= ~strap_n;
        else if (start_cmd) running_q <= 1'b1;
    end

    // Shadow values move to the active copies on every slow tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_act_q <= '0;
            rld_act_q <= RLD_RST;
        end else if (tick) begin
            div_act_q <= div_shadow;
            rld_act_q <= rld_shadow;
        end
    end

    // Divider phase: counts ticks while running; refresh or idle clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                         phase_q <= '0;
        else if (refresh_cmd || !running_q) phase_q <= '0;
        else if (tick)                      phase_q <= phase_end ? '0 : phase_q + 1'b1;
    end

    // Down-counter: a refresh loads it, a step decrements it or wraps to the reload value at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= RLD_RST;
        else if (refresh_cmd) cnt_q <= rld_act_q;
        else if (step)        cnt_q <= (cnt_q == '0) ? rld_act_q : cnt_q - 1'b1;
    end

    // Request: one cycle on a step taken at zero, unless a refresh arrives in that cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= step & (cnt_q == '0) & ~refresh_cmd;
    end

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> !req_q); // R6

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |=> running_q); // R5

    AST_REFRESH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_cmd |=> (cnt_q == $past(rld_act_q))); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_q && !refresh_cmd) |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/wdg_keyed_top.sv
// Module: top of the keyed watchdog. It joins the slow-clock synchronizer, the
// register front end and the count core.
// Assumes slow_clk is asynchronous and much slower than clk.
module wdg_keyed_top #(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 4,
    parameter int DIV_W       = 3,
    parameter int RLD_W       = 12,
    parameter int MAX_CODE    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_n,
    input  logic              slow_clk,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req
);

    localparam logic [RLD_W-1:0] RLD_RST = '1;

    logic             tick;
    logic [DIV_W-1:0] div_shadow;
    logic [RLD_W-1:0] rld_shadow;
    logic             refresh_cmd;
    logic             start_cmd;

    wdg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (slow_clk),
        .tick     (tick)
    );

    wdg_keybus #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .DIV_W   (DIV_W),
        .RLD_W   (RLD_W),
        .RLD_RST (RLD_RST)
    ) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .apply       (tick),
        .div_shadow  (div_shadow),
        .rld_shadow  (rld_shadow),
        .refresh_cmd (refresh_cmd),
        .start_cmd   (start_cmd)
    );

    wdg_count_core #(
        .DIV_W    (DIV_W),
        .RLD_W    (RLD_W),
        .MAX_CODE (MAX_CODE),
        .RLD_RST  (RLD_RST)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_n     (strap_n),
        .tick        (tick),
        .start_cmd   (start_cmd),
        .refresh_cmd (refresh_cmd),
        .div_shadow  (div_shadow),
        .rld_shadow  (rld_shadow),
        .rst_req     (rst_req)
    );

endmodule

// File: tb/tb_wdg_keyed_top.sv
`timescale 1ns/1ps
// Bench: directed scenarios for the keyed watchdog, one task per scenario.
module tb_wdg_keyed_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_n = 1'b1;
    logic        slow_clk = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;
    int run_len = 0;
    int max_run = 0;

    always #2.5 clk = ~clk;

    wdg_keyed_top dut (
        .clk(clk), .rst_n(rst_n), .strap_n(strap_n), .slow_clk(slow_clk),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    // Counts request pulses and records the longest high run.
    always @(negedge clk) begin
        if (rst_req) begin
            pulses  = pulses + 1;
            run_len = run_len + 1;
            if (run_len > max_run) max_run = run_len;
        end else begin
            run_len = 0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        strap_n  = strap;
        slow_clk = 1'b0;
        rst_n    = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic slow_tick(input int high_cycles);
        @(negedge clk);
        slow_clk = 1'b1;
        repeat (high_cycles) @(negedge clk);
        slow_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) slow_tick(3);
    endtask

    // Opens access, programs divider and reload, applies them, then refreshes.
    task automatic setup(input logic [2:0] code, input logic [11:0] rld);
        bus_write(4'h0, 32'h5555);
        bus_write(4'h4, {29'd0, code});
        bus_write(4'h8, {20'd0, rld});
        slow_tick(3);
        bus_write(4'h0, 32'hAAAA);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset(1'b1);
        bus_read(4'h0, d); check("R1 key reads 0", d, 32'h0);
        bus_read(4'h4, d); check("R1 divider reset", d, 32'h0);
        bus_read(4'h8, d); check("R1 reload reset", d, 32'hFFF);
        bus_read(4'hC, d); check("R1 status reset", d, 32'h0);
        check("R1 no request", {31'd0, rst_req}, 32'h0);
    endtask

    task automatic t_access();
        logic [31:0] d;
        do_reset(1'b1);
        bus_write(4'h8, 32'h5);
        bus_read(4'h8, d); check("R3 locked reload write ignored", d, 32'hFFF);
        bus_write(4'h0, 32'h0001_5555);
        bus_write(4'h8, 32'h5);
        bus_read(4'h8, d); check("R2 upper key bits block opening", d, 32'hFFF);
        bus_write(4'h0, 32'h5555);
        bus_write(4'h8, 32'h5);
        bus_write(4'h4, 32'h2);
        bus_read(4'h8, d); check("R2 reload accepted", d, 32'h5);
        bus_read(4'h4, d); check("R2 divider accepted", d, 32'h2);
        bus_read(4'hC, d); check("R4 both pending", d, 32'h3);
        slow_tick(3);
        bus_read(4'hC, d); check("R4 pending cleared by tick", d, 32'h0);
        bus_write(4'h0, 32'h1234);
        bus_write(4'h8, 32'h9);
        bus_write(4'h4, 32'h6);
        bus_read(4'h8, d); check("R3 other key closes, reload kept", d, 32'h5);
        bus_read(4'h4, d); check("R3 other key closes, divider kept", d, 32'h2);
    endtask

    task automatic t_timeout();
        int p0;
        do_reset(1'b1);
        setup(3'd0, 12'd3);
        bus_write(4'h0, 32'hCCCC);
        p0 = pulses;
        ticks(15); check("R6 no request before (3+1)*4 ticks", pulses - p0, 0);
        ticks(1);  check("R6 request at tick 16", pulses - p0, 1);
        ticks(15); check("R6 reloaded, quiet", pulses - p0, 1);
        ticks(1);  check("R6 second timeout same period", pulses - p0, 2);
    endtask

    task automatic t_slow_edges();
        int p0;
        do_reset(1'b1);
        setup(3'd0, 12'd0);
        bus_write(4'h0, 32'hCCCC);
        p0 = pulses;
        ticks(3);
        slow_tick(20);
        check("R10 long high level is one tick", pulses - p0, 1);
        ticks(3);
        check("R10 next period counts edges only", pulses - p0, 1);
    endtask

    task automatic t_refresh();
        int p0;
        do_reset(1'b1);
        setup(3'd0, 12'd3);
        bus_write(4'h0, 32'hCCCC);
        p0 = pulses;
        ticks(10);
        bus_write(4'h0, 32'hAAAA);
        ticks(15); check("R8 refresh postpones timeout", pulses - p0, 0);
        ticks(1);  check("R8 timeout 16 ticks after refresh", pulses - p0, 1);
    endtask

    task automatic run_div(input logic [2:0] code, input int div, input string tag);
        int p0;
        do_reset(1'b1);
        setup(code, 12'd0);
        bus_write(4'h0, 32'hCCCC);
        p0 = pulses;
        ticks(div - 1); check({tag, " quiet before divide"}, pulses - p0, 0);
        ticks(1);       check({tag, " request at divide"}, pulses - p0, 1);
    endtask

    task automatic t_divider();
        run_div(3'd1, 8,   "R7 code1");
        run_div(3'd3, 32,  "R7 code3");
        run_div(3'd7, 256, "R7 code7");
    endtask

    task automatic t_sticky();
        int p0;
        do_reset(1'b1);
        setup(3'd0, 12'd1);
        bus_write(4'h0, 32'hCCCC);
        bus_write(4'h0, 32'h5555);
        bus_write(4'h0, 32'h0);
        bus_write(4'h0, 32'hFFFF_FFFF);
        p0 = pulses;
        ticks(8);
        check("R5 other keys do not stop it", pulses - p0, 1);
    endtask

    task automatic t_strap();
        int p0;
        do_reset(1'b0);
        setup(3'd0, 12'd1);
        p0 = pulses;
        ticks(8);
        check("R9 strap low runs without start", pulses - p0, 1);
        do_reset(1'b1);
        setup(3'd0, 12'd1);
        p0 = pulses;
        ticks(20);
        check("R9 strap high stays idle", pulses - p0, 0);
        bus_write(4'h0, 32'hCCCC);
        ticks(8);
        check("R5 start key then runs", pulses - p0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_access();
        t_timeout();
        t_slow_edges();
        t_refresh();
        t_divider();
        t_sticky();
        t_strap();
        check("R6 request width one cycle", max_run, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule